// File: doc/BRIEF.md
# Phase-Staggered Six-Channel PWM Dimmer

This block produces six pulse-width-modulated gate signals, one for each LED current sink. All six share one 8-bit brightness value and one dimming period. The period is 255 counts of a step tick supplied from outside, so the tick rate sets the dimming frequency. The start of each channel's pulse can be moved within the period, which spreads the switching edges over time and lowers ripple and load transients. Three placements are available: all channels aligned, channels spread evenly over the period, or each channel offset from the previous one by a programmable 7-bit step.

Brightness, placement mode and step value are captured only when a period begins, so a change in the middle of a period cannot leave a pulse cut short. The channel enable mask acts on the next clock. A one-clock strobe marks the start of each period so that surrounding logic can line up with it.

Top module: `phase_pwm_dimmer`

## Requirements
- R1: A period counter runs from 0 to 254. It advances by one only on a clock where `stepTick` is 1 and goes from 254 back to 0. With no tick, every output keeps its value.
- R2: When the captured `phaseMode` is 0 (aligned) or 3 (spare), every channel's pulse starts at count 0.
- R3: When the captured `phaseMode` is 1 (equal spacing), channel k (bit k of `pwmOut`) starts at floor(k*255/6). That gives counts 0, 42, 85, 127, 170 and 212.
- R4: When the captured `phaseMode` is 2 (stepped), channel k starts at (k*`phaseStep`) mod 255, and its pulse continues past the period boundary.
- R5: An enabled channel is high when (count - start) mod 255 is less than the captured brightness. Its output follows the counter with a delay of one clock.
- R6: A brightness of 0 keeps every output low. A brightness of 255 keeps every enabled output high for the whole period.
- R7: Brightness, mode and step are captured only on the tick that takes the counter from 254 to 0. Changes at any other time have no effect until that tick.
- R8: An output whose `chanEnable` bit is 0 is low from the next clock on, whatever the other settings are.
- R9: `periodStart` is high for exactly one clock, the clock in which the counter has just become 0.
- R10: After reset, all outputs are low, the captured brightness is 0 and the counter sits at 254, so the first tick starts a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepTick | input | 1 | Advances the period counter by one count |
| brightness | input | 8 | Duty value; pulse length in counts out of 255 |
| phaseMode | input | 2 | 0 aligned, 1 equal spacing, 2 stepped, 3 treated as aligned |
| phaseStep | input | 7 | Offset between successive channels in stepped mode |
| chanEnable | input | 6 | Per-channel enable mask, bit k for channel k |
| pwmOut | output | 6 | PWM gate outputs, bit k for channel k |
| periodStart | output | 1 | One-clock strobe at the start of each period |

## Verification
On every clock, the embedded properties check the following. The counter stays within its 255-count range, and without a tick it holds still. The period strobe appears only when the count is zero. A masked channel never drives high. Zero brightness gives all-low outputs and full brightness gives exactly the enable mask. In aligned mode the enabled outputs are all high together or all low together. The start offsets of the equal and stepped placements, wrap-around of a pulse past the period boundary, and the fact that settings written in the middle of a period are held off until the next start can only be shown by the bench scenarios, which compare outputs at chosen counts against values worked out from the requirements.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

  typedef enum logic [1:0] {
    PH_ALIGNED = 2'd0,
    PH_EQUAL   = 2'd1,
    PH_STEPPED = 2'd2,
    PH_SPARE   = 2'd3
  } phase_mode_e;

  // Strobes passed from the period control to the datapath
  typedef struct packed {
    logic load;   // counter wraps on this clock: capture settings
  } pwm_strobe_t;

endpackage

// File: rtl/phase_pwm_ctrl.sv
module phase_pwm_ctrl
  import phase_pwm_pkg::*;
#(
  parameter int BRI_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepTick,
  output logic [BRI_W-1:0] cnt,
  output pwm_strobe_t      strb,
  output logic             periodStart
);

  localparam int PERIOD = (1 << BRI_W) - 1;
  localparam logic [BRI_W-1:0] LAST = BRI_W'(PERIOD - 1);

  always_comb strb.load = stepTick && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= LAST;
      periodStart <= 1'b0;
    end else begin
      periodStart <= strb.load;
      if (stepTick) cnt <= strb.load ? '0 : cnt + 1'b1;
    end
  end

  // R1: counter stays inside the period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);
  // R1: without a tick the counter holds
  a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !stepTick |=> $stable(cnt));
  // R9: strobe only at count zero
  a_r9_strobe_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |-> (cnt == '0));

endmodule

// File: rtl/phase_pwm_datapath.sv
module phase_pwm_datapath
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int BRI_W   = 8,
  parameter int SHIFT_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BRI_W-1:0]   cnt,
  input  pwm_strobe_t        strb,
  input  logic [BRI_W-1:0]   brightness,
  input  logic [1:0]         phaseMode,
  input  logic [SHIFT_W-1:0] phaseStep,
  input  logic [NUM_CH-1:0]  chanEnable,
  output logic [NUM_CH-1:0]  pwmOut
);

  localparam int PERIOD = (1 << BRI_W) - 1;
  localparam logic [BRI_W-1:0] FULL = BRI_W'(PERIOD);

  logic [BRI_W-1:0] shBri;
  phase_mode_e      shMode;
  phase_mode_e      modeIn;
  logic [BRI_W-1:0] startReg  [NUM_CH];
  logic [BRI_W-1:0] startNext [NUM_CH];
  logic [BRI_W-1:0] phase     [NUM_CH];

  always_comb modeIn = phase_mode_e'(phaseMode);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int EQ_START = (k * PERIOD) / NUM_CH;

    always_comb begin
      int unsigned prod;
      prod = int'(k) * int'(phaseStep);
      case (modeIn)
        PH_EQUAL:   startNext[k] = BRI_W'(EQ_START);
        PH_STEPPED: startNext[k] = BRI_W'(prod % PERIOD);
        default:    startNext[k] = '0;
      endcase
    end

    // Distance from this channel's start, modulo the period
    always_comb begin
      if (cnt >= startReg[k]) phase[k] = cnt - startReg[k];
      else                    phase[k] = cnt + FULL - startReg[k];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startReg[k] <= '0;
        pwmOut[k]   <= 1'b0;
      end else begin
        if (strb.load) startReg[k] <= startNext[k];
        pwmOut[k] <= chanEnable[k] && (phase[k] < shBri);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shBri  <= '0;
      shMode <= PH_ALIGNED;
    end else if (strb.load) begin
      shBri  <= brightness;
      shMode <= modeIn;
    end
  end

  // R8: masked channels never drive high
  a_r8_masked_low: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pwmOut & ~$past(chanEnable)) == '0));
  // R6: zero brightness gives dark outputs
  a_r6_zero_dark: assert property (@(posedge clk) disable iff (!rstN)
    (shBri == '0) |=> (pwmOut == '0));
  // R6: full brightness follows the enable mask
  a_r6_full_on: assert property (@(posedge clk) disable iff (!rstN)
    (shBri == FULL) |=> (pwmOut == $past(chanEnable)));
  // R2: aligned mode switches enabled channels together
  a_r2_aligned_together: assert property (@(posedge clk) disable iff (!rstN)
    ((shMode == PH_ALIGNED) || (shMode == PH_SPARE))
      |=> ((pwmOut == '0) || (pwmOut == $past(chanEnable))));

endmodule

// File: rtl/phase_pwm_dimmer.sv
module phase_pwm_dimmer
  import phase_pwm_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int BRI_W   = 8,
  parameter int SHIFT_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepTick,
  input  logic [BRI_W-1:0]   brightness,
  input  logic [1:0]         phaseMode,
  input  logic [SHIFT_W-1:0] phaseStep,
  input  logic [NUM_CH-1:0]  chanEnable,
  output logic [NUM_CH-1:0]  pwmOut,
  output logic               periodStart
);

  logic [BRI_W-1:0] cnt;
  pwm_strobe_t      strb;

  phase_pwm_ctrl #(.BRI_W(BRI_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stepTick    (stepTick),
    .cnt         (cnt),
    .strb        (strb),
    .periodStart (periodStart)
  );

  phase_pwm_datapath #(
    .NUM_CH  (NUM_CH),
    .BRI_W   (BRI_W),
    .SHIFT_W (SHIFT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .cnt        (cnt),
    .strb       (strb),
    .brightness (brightness),
    .phaseMode  (phaseMode),
    .phaseStep  (phaseStep),
    .chanEnable (chanEnable),
    .pwmOut     (pwmOut)
  );

endmodule

// File: tb/test_phase_pwm_dimmer.sv
module test_phase_pwm_dimmer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepTick = 1'b0;
  logic [7:0] brightness = '0;
  logic [1:0] phaseMode = '0;
  logic [6:0] phaseStep = '0;
  logic [5:0] chanEnable = '0;
  logic [5:0] pwmOut;
  logic       periodStart;

  int checks = 0;
  int fails  = 0;
  int benchCnt = 254;

  always #5 clk = ~clk;

  phase_pwm_dimmer i_phase_pwm_dimmer (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .brightness(brightness),
    .phaseMode(phaseMode), .phaseStep(phaseStep), .chanEnable(chanEnable),
    .pwmOut(pwmOut), .periodStart(periodStart)
  );

  typedef struct packed {
    logic [7:0] bri;
    logic [1:0] mode;
    logic [6:0] step;
    logic [5:0] en;
    logic [7:0] pos;
    logic [5:0] exp;
  } vec_t;

  // Expected values worked out by hand from R2..R6
  localparam vec_t VECS [9] = '{
    '{8'd100, 2'd0, 7'd0,   6'h3F, 8'd50,  6'h3F},  // R2 R5 aligned, inside pulse
    '{8'd100, 2'd0, 7'd0,   6'h3F, 8'd150, 6'h00},  // R5 aligned, after pulse
    '{8'd50,  2'd1, 7'd0,   6'h3F, 8'd60,  6'h02},  // R3 equal, ch1 only
    '{8'd50,  2'd1, 7'd0,   6'h3F, 8'd230, 6'h20},  // R3 equal, ch5 only
    '{8'd0,   2'd1, 7'd0,   6'h3F, 8'd0,   6'h00},  // R6 zero brightness
    '{8'd255, 2'd1, 7'd0,   6'h2D, 8'd10,  6'h2D},  // R6 R8 full with mask
    '{8'd25,  2'd2, 7'd10,  6'h3F, 8'd30,  6'h0E},  // R4 stepped by 10
    '{8'd60,  2'd2, 7'd100, 6'h3F, 8'd20,  6'h21},  // R4 stepped, ch5 wraps
    '{8'd1,   2'd2, 7'd127, 6'h3F, 8'd0,   6'h01}   // R4 max step, minimum duty
  };

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) stepTick = 1'b1;
    @(negedge clk) stepTick = 1'b0;
    benchCnt = (benchCnt == 254) ? 0 : benchCnt + 1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic toStart();
    do tick(); while (benchCnt != 0);
  endtask

  task automatic tickTo(int target);
    while (benchCnt != target) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pwm after reset", pwmOut, 6'h00);
    check("R10 strobe after reset", {5'b0, periodStart}, 6'h00);
    rstN = 1'b1;
    settle();
    // R10 R9: first tick starts a period, strobe lasts one clock
    tick();
    check("R9 R10 strobe on first tick", {5'b0, periodStart}, 6'h01);
    settle();
    check("R9 strobe one clock", {5'b0, periodStart}, 6'h00);

    foreach (VECS[i]) begin
      brightness = VECS[i].bri;
      phaseMode  = VECS[i].mode;
      phaseStep  = VECS[i].step;
      chanEnable = VECS[i].en;
      toStart();
      tickTo(int'(VECS[i].pos));
      settle();
      check($sformatf("R2-5 vector %0d", i), pwmOut, VECS[i].exp);
    end

    // R1: no tick means no advance; R5 pulse ends at count == brightness
    brightness = 8'd100; phaseMode = 2'd0; chanEnable = 6'h3F;
    toStart();
    tickTo(99);
    repeat (20) @(negedge clk);
    check("R1 held without tick", pwmOut, 6'h3F);
    tick(); settle();
    check("R5 pulse end at count 100", pwmOut, 6'h00);

    // R6 full brightness, R8 mask applies next clock
    brightness = 8'd255; phaseMode = 2'd0; chanEnable = 6'h3F;
    toStart();
    tickTo(5); settle();
    check("R6 full brightness", pwmOut, 6'h3F);
    chanEnable = 6'h0A;
    settle();
    check("R8 mask mid-period", pwmOut, 6'h0A);

    // R7: mid-period changes held off until the wrap
    brightness = 8'd0; phaseMode = 2'd1;
    tickTo(100); settle();
    check("R7 settings held mid-period", pwmOut, 6'h0A);
    toStart(); settle();
    check("R7 settings taken at wrap", pwmOut, 6'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule